// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Register Slave

This block connects an external controller to a chip's internal registers over one shared 16-bit bidirectional address/data bus. A cycle has two phases. In the address phase, the controller asserts the address-latch strobe and places the register address on the shared bus. In the data phase, the controller pulls chip select low and sets the direction input. The slave then answers with a one-clock active-low ready pulse. It samples write data on that edge, and it drives read data on the bus while the read data phase lasts.

Address bit 1 does not travel on the shared bus. It comes from a dedicated pin that is sampled at the start of the data phase. A mode pin picks one of two controller bus styles. Style 0 has an active-high latch strobe and a direction pin that is high for write. Style 1 has an active-low latch strobe and a direction pin that is high for read. The two lowest register addresses are handled inside the block: a pending-event flag register and an interrupt enable register. All other addresses are passed to a register-file port. The active-low interrupt output is asserted whenever an enabled flag is pending.

Top module: `mux_bus_slave`

## Requirements
- R1: The register address is taken from the shared bus on every clock edge where the latch strobe is active: `ale` high when `bus_mode`=0, `ale` low when `bus_mode`=1. The last value latched is the one used.
- R2: Address bit 1 comes from the `a1` pin, sampled on the first clock edge of the data phase. Bus bit 1 of the latched address is ignored.
- R3: Direction is `wr_rd`=1 for write when `bus_mode`=0, and `wr_rd`=0 for write when `bus_mode`=1.
- R4: Counting the first rising edge with `cs_n` low and the strobe inactive as edge 0, `rdy_n` goes low after edge 1 and high again after edge 2. While the slave is selected, `rdy_n` is high at all other times.
- R5: The slave drives the shared bus only in a read data phase with `cs_n` low. It drives it from edge 1 on, with the data of the addressed register.
- R6: A write to an address of 2 or above produces exactly one `rf_we` pulse, carrying the address and the bus data, which commit on edge 2. A read of such an address returns `rf_rdata`. Addresses 0 and 1 never pulse `rf_we`.
- R7: An `evt` bit high on a clock edge sets the matching bit of the flag register (address 0, bits NEV-1:0). The bit stays set until it is cleared.
- R8: Writing to address 0 clears each flag bit whose write-data bit is 1. Bits written with 0 are unchanged.
- R9: If an event arrives on the same edge that clears its flag, the flag stays set.
- R10: `irq_n` is low exactly when some flag bit is set and the matching bit of the enable register (address 1, bits NEV-1:0) is also set.
- R11: After reset, flags and enables are zero and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address-latch strobe (polarity set by bus_mode) |
| cs_n | input | 1 | Active-low chip select |
| wr_rd | input | 1 | Cycle direction (meaning set by bus_mode) |
| a1 | input | 1 | Dedicated address bit 1 |
| bus_mode | input | 1 | Bus style: 0 or 1 |
| adio | inout | 16 | Shared address/data bus |
| rdy_n | output | 1 | Active-low ready, high-impedance when not selected |
| irq_n | output | 1 | Active-low interrupt request |
| evt | input | NEV | Internal event pulses setting flags |
| rf_addr | output | AW | Register-file address |
| rf_we | output | 1 | Register-file write strobe |
| rf_re | output | 1 | Register-file read strobe |
| rf_wdata | output | 16 | Register-file write data |
| rf_rdata | input | 16 | Register-file read data |

## Verification
An event pulse and a controller write that clears the same flag can fall on the same clock edge. The bench provokes this by raising `evt` in the ready cycle of a write to address 0, so both land on edge 2. A read-back of the flag register then has to show the bit still set, while flags that were cleared without a competing event must read back as zero.

// File: rtl/mux_bus_slave.sv
module mux_bus_slave #(
  parameter int AW  = 8,
  parameter int NEV = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ale,
  input  logic           cs_n,
  input  logic           wr_rd,
  input  logic           a1,
  input  logic           bus_mode,
  inout  wire  [15:0]    adio,
  output wire            rdy_n,
  output logic           irq_n,
  input  logic [NEV-1:0] evt,
  output logic [AW-1:0]  rf_addr,
  output logic           rf_we,
  output logic           rf_re,
  output logic [15:0]    rf_wdata,
  input  logic [15:0]    rf_rdata
);

  localparam logic [AW-1:0] FLAG_ADDR = AW'(0);
  localparam logic [AW-1:0] EN_ADDR   = AW'(1);

  logic           strb, is_wr, sel, oe, rdy_act, a1_q, local_hit;
  logic [1:0]     cnt;
  logic [AW-1:0]  lat, addr;
  logic [15:0]    rd_q, rd_mux;
  logic [NEV-1:0] flags, en, clr;

  assign strb      = bus_mode ? ~ale : ale;
  assign is_wr     = bus_mode ? ~wr_rd : wr_rd;
  assign sel       = ~cs_n & ~strb;
  assign addr      = {lat[AW-1:2], a1_q, lat[0]};
  assign local_hit = (addr[AW-1:1] == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lat <= '0;
    else if (strb) lat <= adio[AW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '0;
      a1_q    <= 1'b0;
      rdy_act <= 1'b0;
      rd_q    <= '0;
    end else begin
      rdy_act <= sel && (cnt == 2'd1);
      if (!sel) cnt <= '0;
      else if (cnt != 2'd3) cnt <= cnt + 2'd1;
      if (sel && cnt == 2'd0) a1_q <= a1;
      if (sel && cnt == 2'd1) rd_q <= rd_mux;
    end

  always_comb begin
    rd_mux = rf_rdata;
    if (addr == FLAG_ADDR) rd_mux = 16'(flags);
    else if (addr == EN_ADDR) rd_mux = 16'(en);
  end

  assign rf_addr  = addr;
  assign rf_wdata = adio;
  assign rf_re    = sel && (cnt == 2'd1) && !is_wr && !local_hit;
  assign rf_we    = rdy_act && sel && is_wr && !local_hit;

  assign clr = (rdy_act && sel && is_wr && addr == FLAG_ADDR) ? adio[NEV-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flags <= '0;
      en    <= '0;
    end else begin
      flags <= (flags & ~clr) | evt;
      if (rdy_act && sel && is_wr && addr == EN_ADDR) en <= adio[NEV-1:0];
    end

  assign oe    = sel && !is_wr && cnt[1];
  assign adio  = oe ? rd_q : 16'bz;
  assign rdy_n = cs_n ? 1'bz : ~rdy_act;
  assign irq_n = ~|(flags & en);

endmodule

// File: rtl/mux_bus_slave_chk.sv
module mux_bus_slave_chk #(
  parameter int AW  = 8,
  parameter int NEV = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs_n,
  input logic           is_wr,
  input logic           oe,
  input logic           rdy_act,
  input logic [1:0]     cnt,
  input logic           rf_we,
  input logic           irq_n,
  input logic [NEV-1:0] evt,
  input logic [NEV-1:0] flags
);

  // R4
  rdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_act |=> !rdy_act);

  // R5
  bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (!cs_n && !is_wr));

  // R6
  rf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (!cs_n && is_wr && cnt == 2'd2));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (|flags));

endmodule

bind mux_bus_slave mux_bus_slave_chk #(.AW(AW), .NEV(NEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .is_wr(is_wr), .oe(oe),
  .rdy_act(rdy_act), .cnt(cnt), .rf_we(rf_we), .irq_n(irq_n),
  .evt(evt), .flags(flags)
);

// File: tb/test_mux_bus_slave.sv
module test_mux_bus_slave;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int NEV = 8;

  logic clk = 0, rst_n = 0, ale = 0, cs_n = 1, wr_rd = 0, a1 = 0, bus_mode = 0;
  logic [NEV-1:0] evt = '0;
  logic tb_drv = 0;
  logic [15:0] tb_d = '0;
  wire  [15:0] adio;
  wire  rdy_n;
  logic irq_n, rf_we, rf_re;
  logic [AW-1:0] rf_addr;
  logic [15:0] rf_wdata, rf_rdata;

  logic [15:0] mem [0:(1<<AW)-1];
  logic [15:0] exp_mem [0:(1<<AW)-1];
  int we_cnt = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  assign adio = tb_drv ? tb_d : 16'bz;
  assign rf_rdata = mem[rf_addr];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rf_we) begin
    mem[rf_addr] <= rf_wdata;
    we_cnt <= we_cnt + 1;
  end

  mux_bus_slave #(.AW(AW), .NEV(NEV)) i_mux_bus_slave (
    .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .wr_rd(wr_rd), .a1(a1),
    .bus_mode(bus_mode), .adio(adio), .rdy_n(rdy_n), .irq_n(irq_n), .evt(evt),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_re(rf_re), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] scramble_bit1(logic [AW-1:0] a);
    return 16'(a) ^ 16'h0002;
  endfunction

  task automatic access(input bit mode, input bit wr, input logic [AW-1:0] a,
                        input logic [15:0] data, input logic [NEV-1:0] ev,
                        output logic [15:0] rd);
    @(negedge clk);
    bus_mode = mode;
    ale = mode ? 1'b0 : 1'b1;
    tb_drv = 1; tb_d = scramble_bit1(a);
    @(negedge clk);
    ale = mode ? 1'b1 : 1'b0;
    cs_n = 0; a1 = a[1];
    wr_rd = mode ? ~wr : wr;
    if (wr) tb_d = data; else tb_drv = 0;
    @(negedge clk);
    chk(rdy_n === 1'b1, "R4 ready high after edge 0", {15'd0, rdy_n}, 16'd1);
    @(negedge clk);
    chk(rdy_n === 1'b0, "R4 ready low after edge 1", {15'd0, rdy_n}, 16'd0);
    rd = adio;
    evt = ev;
    @(negedge clk);
    evt = '0;
    chk(rdy_n === 1'b1, "R4 ready high after edge 2", {15'd0, rdy_n}, 16'd1);
    cs_n = 1; tb_drv = 0;
  endtask

  task automatic wr_reg(input bit mode, input logic [AW-1:0] a, input logic [15:0] d);
    logic [15:0] dummy;
    access(mode, 1'b1, a, d, '0, dummy);
  endtask

  task automatic rd_reg(input bit mode, input logic [AW-1:0] a, output logic [15:0] d);
    access(mode, 1'b0, a, 16'h0, '0, d);
  endtask

  task automatic pulse(input logic [NEV-1:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    logic [15:0] r;
    int w0;
    void'($urandom(32'd1234));
    for (int i = 0; i < (1<<AW); i++) begin mem[i] = '0; exp_mem[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(irq_n === 1'b1, "R11 irq after reset", {15'd0, irq_n}, 16'd1);
    rd_reg(0, 0, r); chk(r === 16'h0, "R11 flags after reset", r, 16'h0);
    rd_reg(1, 1, r); chk(r === 16'h0, "R11 enables after reset", r, 16'h0);

    w0 = we_cnt;
    wr_reg(0, 1, 16'h000F);
    rd_reg(1, 1, r); chk(r === 16'h000F, "R3 enable write mode0", r, 16'h000F);
    chk(we_cnt == w0, "R6 no rf write for local", 16'(we_cnt - w0), 16'h0);

    pulse(8'h30);
    @(negedge clk);
    chk(irq_n === 1'b1, "R10 masked flags no irq", {15'd0, irq_n}, 16'd1);
    rd_reg(0, 0, r); chk(r === 16'h0030, "R7 flags set", r, 16'h0030);
    pulse(8'h01);
    @(negedge clk);
    chk(irq_n === 1'b0, "R10 enabled flag irq", {15'd0, irq_n}, 16'd0);

    wr_reg(1, 0, 16'h0001);
    rd_reg(1, 0, r); chk(r === 16'h0030, "R8 clear one flag mode1", r, 16'h0030);
    chk(irq_n === 1'b1, "R10 irq released", {15'd0, irq_n}, 16'd1);

    // R9 collision: clear 0x30 while event 0x10 arrives on the commit edge
    access(0, 1'b1, 0, 16'h0030, 8'h10, r);
    rd_reg(0, 0, r); chk(r === 16'h0010, "R9 set wins over clear", r, 16'h0010);

    // R2 dedicated address bit
    wr_reg(0, 8'h06, 16'hBEEF); exp_mem[6] = 16'hBEEF;
    rd_reg(1, 8'h04, r); chk(r === 16'h0000, "R2 bit1 from pin only", r, 16'h0000);
    rd_reg(0, 8'h06, r); chk(r === 16'hBEEF, "R2 readback", r, 16'hBEEF);
    chk(mem[6] === 16'hBEEF, "R6 rf write data", mem[6], 16'hBEEF);

    // R1 R3 R5 R6 random
    for (int k = 0; k < 40; k++) begin
      logic [AW-1:0] a;
      logic [15:0] d;
      bit m;
      a = AW'($urandom_range((1<<AW)-1, 2));
      d = 16'($urandom);
      m = 1'($urandom);
      w0 = we_cnt;
      wr_reg(m, a, d); exp_mem[a] = d;
      chk(we_cnt == w0 + 1, "R6 one rf write", 16'(we_cnt - w0), 16'h1);
      rd_reg(~m, a, r);
      chk(r === exp_mem[a], "R1 R3 R5 random readback", r, exp_mem[a]);
    end
    rd_reg(1, 8'h06, r); chk(r === exp_mem[6], "R1 earlier data kept", r, exp_mem[6]);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule